// File: doc/BRIEF.md
# Display Power-Save and Host-Gate Register Block

This block holds the small set of control bits that a display controller needs for power saving and for keeping the host away from memory and registers until firmware is ready. It drives the panel supply output, asks the memory side to enter suspend, tells the DRAM controller which refresh scheme to run while suspended, and says whether the half frame buffer is in use. It also produces a qualifier that downstream memory and register decode use to allow or refuse host cycles.

Firmware reaches the block through a one-cycle request port with an address, a write enable and write data. Every request is acknowledged one clock later, with read data in the same cycle. After reset only the status register and the miscellaneous register answer. Every other access is acknowledged but has no effect until the host-gate bit is cleared. The off level of the panel supply is taken from a strap input while reset is held. The panel supply either follows an external on/off sequencer or is forced off by a control bit.

Top module: `psave_ctrl`

## Requirements
- R1: While reset is held and right after it is released, `regAck` is 0, `hostAccessOk` is 0, `suspReq` is 0, `refMode` is 00, `hfbEn` equals `!singlePanel`, and `panelPwr` sits at the off level.
- R2: The off level of `panelPwr` is the value of `strapPwrPol` in the last clock cycle with `rstN` low. Strap 1 makes 1 the off level and strap 0 makes 0 the off level. Strap changes after reset have no effect.
- R3: `panelPwr` is registered. One clock after the power-disable bit (bit 3 at address 2) is 1, it is at the off level. When that bit is 0, it is at the on level one clock after `seqPwrOn` is 1 and at the off level one clock after `seqPwrOn` is 0.
- R4: The refresh field is bits 2:1 at address 2. `refMode` shows 00 for CAS-before-RAS refresh when the field is 00, and 01 for self-refresh when the field is 01. Field values 10 and 11 both show as 10, meaning no refresh.
- R5: Bit 0 at address 2 is the suspend enable. `suspReq` follows it one clock after the write.
- R6: A write to address 2 made while suspend enable is already 1 leaves the refresh field unchanged. The same write still updates the suspend enable and power-disable bits.
- R7: The host-gate bit is bit 7 at address 1 and resets to 1. `hostAccessOk` is its inverse.
- R8: While the host-gate bit is 1, a request to any address other than 0 (status) or 1 (miscellaneous) is still acknowledged, but its write is dropped and its read returns zero.
- R9: Bit 0 at address 1 disables the half frame buffer. `hfbEn` is 1 only when that bit is 0 and `singlePanel` is 0.
- R10: `regAck` is 1 exactly one clock after each cycle with `regReq` high. Read data appears with that acknowledge, and a write's acknowledge carries zero data.
- R11: Status at address 0 is read-only. Bit 0 holds the latched off level, bit 1 holds suspend enable and bit 2 holds `singlePanel`. Bits without a function read as 0 at every address, and unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| strapPwrPol | input | 1 | Strap giving the panel supply off level, captured during reset |
| seqPwrOn | input | 1 | Request from the panel on/off sequencer, 1 = on |
| singlePanel | input | 1 | 1 when a single panel is attached |
| regReq | input | 1 | Register access request, one cycle per access |
| regWe | input | 1 | 1 = write, 0 = read |
| regAddr | input | ADDR_W | Register address |
| regWdata | input | DATA_W | Write data |
| regAck | output | 1 | Acknowledge, one clock after the request |
| regRdata | output | DATA_W | Read data, valid with the acknowledge |
| panelPwr | output | 1 | Panel supply control |
| suspReq | output | 1 | Suspend request to the memory side |
| refMode | output | 2 | Suspend refresh type: 00 CBR, 01 self, 10 none |
| hfbEn | output | 1 | Half frame buffer in use |
| hostAccessOk | output | 1 | Host accesses permitted downstream |

## Verification
Acknowledge, read data, control bits, `suspReq`, `refMode` and `hostAccessOk` all settle at the first rising edge after the request. The bench therefore samples them 2 ns after that edge and compares them against a model that has applied the access. `panelPwr` is registered from the stored power-disable bit and the sequencer input. Its expected value therefore comes from the model state held before that same edge, so a write to the disable bit shows at the panel one edge later. `hfbEn` is combinational and is compared against the model and the panel-mode input as driven.

// File: rtl/psave_pkg.sv
package psave_pkg;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_STAT = 2'd1,
    RD_MISC = 2'd2,
    RD_PWR  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrPwr;
    logic   wrMisc;
    rdSel_e rdSel;
    logic   granted;
  } ctlStrb_t;

  localparam int STAT_POL_BIT    = 0;
  localparam int STAT_SUSP_BIT   = 1;
  localparam int STAT_SINGLE_BIT = 2;

  localparam int PWR_SUSP_BIT = 0;
  localparam int PWR_REF_LSB  = 1;
  localparam int PWR_PDIS_BIT = 3;

  localparam int MISC_HFB_BIT = 0;

  localparam logic [1:0] REF_CBR  = 2'b00;
  localparam logic [1:0] REF_SELF = 2'b01;
  localparam logic [1:0] REF_NONE = 2'b10;

endpackage

// File: rtl/psave_ctl.sv
module psave_ctl
  import psave_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int STAT_ADDR = 0,
  parameter int MISC_ADDR = 1,
  parameter int PWR_ADDR  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regReq,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              hostDis,
  output ctlStrb_t          strb,
  output logic              regAck
);

  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_MISC = ADDR_W'(MISC_ADDR);
  localparam logic [ADDR_W-1:0] A_PWR  = ADDR_W'(PWR_ADDR);

  logic hitStat;
  logic hitMisc;
  logic hitPwr;
  logic alwaysOpen;
  logic granted;

  always_comb begin
    hitStat    = (regAddr == A_STAT);
    hitMisc    = (regAddr == A_MISC);
    hitPwr     = (regAddr == A_PWR);
    alwaysOpen = hitStat | hitMisc;
    granted    = regReq & (alwaysOpen | ~hostDis);
  end

  always_comb begin
    strb         = '0;
    strb.granted = granted;
    strb.wrPwr   = granted & regWe & hitPwr;
    strb.wrMisc  = granted & regWe & hitMisc;
    strb.rdSel   = RD_NONE;
    if (granted && !regWe) begin
      if (hitStat)      strb.rdSel = RD_STAT;
      else if (hitMisc) strb.rdSel = RD_MISC;
      else if (hitPwr)  strb.rdSel = RD_PWR;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) regAck <= 1'b0;
    else       regAck <= regReq;
  end

endmodule

// File: rtl/psave_dp.sv
module psave_dp
  import psave_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapPwrPol,
  input  logic              seqPwrOn,
  input  logic              singlePanel,
  input  logic [DATA_W-1:0] regWdata,
  input  ctlStrb_t          strb,
  output logic [DATA_W-1:0] regRdata,
  output logic              panelPwr,
  output logic              suspReq,
  output logic [1:0]        refMode,
  output logic              hfbEn,
  output logic              hostDis,
  output logic              pwrDisQ,
  output logic              offPolQ
);

  localparam int HDIS_BIT = DATA_W - 1;

  logic       suspEnQ;
  logic [1:0] refSelQ;
  logic       hfbDisQ;
  logic       hostDisQ;
  logic       offPol;
  logic       pwrDis;
  logic       panelPwrQ;
  logic [DATA_W-1:0] statWord;
  logic [DATA_W-1:0] miscWord;
  logic [DATA_W-1:0] pwrWord;
  logic [DATA_W-1:0] rdMux;
  logic       panelNext;

  always_ff @(posedge clk) begin
    if (!rstN) offPol <= strapPwrPol;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      suspEnQ <= 1'b0;
      refSelQ <= REF_CBR;
      pwrDis  <= 1'b0;
    end else if (strb.wrPwr) begin
      suspEnQ <= regWdata[PWR_SUSP_BIT];
      pwrDis  <= regWdata[PWR_PDIS_BIT];
      if (!suspEnQ) refSelQ <= regWdata[PWR_REF_LSB +: 2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostDisQ <= 1'b1;
      hfbDisQ  <= 1'b0;
    end else if (strb.wrMisc) begin
      hostDisQ <= regWdata[HDIS_BIT];
      hfbDisQ  <= regWdata[MISC_HFB_BIT];
    end
  end

  always_comb begin
    if (pwrDis)        panelNext = offPol;
    else if (seqPwrOn) panelNext = ~offPol;
    else               panelNext = offPol;
  end

  always_ff @(posedge clk) begin
    if (!rstN) panelPwrQ <= strapPwrPol;
    else       panelPwrQ <= panelNext;
  end

  always_comb begin
    statWord = '0;
    statWord[STAT_POL_BIT]    = offPol;
    statWord[STAT_SUSP_BIT]   = suspEnQ;
    statWord[STAT_SINGLE_BIT] = singlePanel;
    miscWord = '0;
    miscWord[HDIS_BIT]     = hostDisQ;
    miscWord[MISC_HFB_BIT] = hfbDisQ;
    pwrWord = '0;
    pwrWord[PWR_SUSP_BIT]        = suspEnQ;
    pwrWord[PWR_REF_LSB +: 2]    = refSelQ;
    pwrWord[PWR_PDIS_BIT]        = pwrDis;
    unique case (strb.rdSel)
      RD_STAT: rdMux = statWord;
      RD_MISC: rdMux = miscWord;
      RD_PWR:  rdMux = pwrWord;
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) regRdata <= '0;
    else       regRdata <= rdMux;
  end

  always_comb begin
    if (refSelQ[1]) refMode = REF_NONE;
    else if (refSelQ[0]) refMode = REF_SELF;
    else refMode = REF_CBR;
  end

  assign panelPwr = panelPwrQ;
  assign suspReq  = suspEnQ;
  assign hfbEn    = ~hfbDisQ & ~singlePanel;
  assign hostDis  = hostDisQ;
  assign pwrDisQ  = pwrDis;
  assign offPolQ  = offPol;

endmodule

// File: rtl/psave_ctrl.sv
module psave_ctrl
  import psave_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int STAT_ADDR = 0,
  parameter int MISC_ADDR = 1,
  parameter int PWR_ADDR  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapPwrPol,
  input  logic              seqPwrOn,
  input  logic              singlePanel,
  input  logic              regReq,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic              regAck,
  output logic [DATA_W-1:0] regRdata,
  output logic              panelPwr,
  output logic              suspReq,
  output logic [1:0]        refMode,
  output logic              hfbEn,
  output logic              hostAccessOk
);

  ctlStrb_t strb;
  logic     hostDis;
  logic     pwrDisQ;
  logic     offPolQ;

  psave_ctl #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .MISC_ADDR(MISC_ADDR), .PWR_ADDR(PWR_ADDR)
  ) i_ctl (
    .clk(clk), .rstN(rstN), .regReq(regReq), .regWe(regWe), .regAddr(regAddr),
    .hostDis(hostDis), .strb(strb), .regAck(regAck)
  );

  psave_dp #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strapPwrPol(strapPwrPol), .seqPwrOn(seqPwrOn),
    .singlePanel(singlePanel), .regWdata(regWdata), .strb(strb),
    .regRdata(regRdata), .panelPwr(panelPwr), .suspReq(suspReq),
    .refMode(refMode), .hfbEn(hfbEn), .hostDis(hostDis),
    .pwrDisQ(pwrDisQ), .offPolQ(offPolQ)
  );

  assign hostAccessOk = ~hostDis;

endmodule

// File: rtl/psave_chk.sv
module psave_chk #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int STAT_ADDR = 0,
  parameter int MISC_ADDR = 1,
  parameter int PWR_ADDR  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              seqPwrOn,
  input logic              singlePanel,
  input logic              regReq,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic              regAck,
  input logic [DATA_W-1:0] regRdata,
  input logic              panelPwr,
  input logic              suspReq,
  input logic [1:0]        refMode,
  input logic              hfbEn,
  input logic              hostAccessOk,
  input logic              pwrDisQ,
  input logic              offPolQ
);

  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    regReq |=> regAck); // R10
  AST_NO_STRAY_ACK: assert property (@(posedge clk) disable iff (!rstN)
    !regReq |=> !regAck); // R10
  AST_FORCED_OFF: assert property (@(posedge clk) disable iff (!rstN)
    pwrDisQ |=> (panelPwr == offPolQ)); // R3
  AST_POL_HELD: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> $stable(offPolQ)); // R2
  AST_REF_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    suspReq |=> $stable(refMode)); // R6
  AST_SINGLE_NO_HFB: assert property (@(posedge clk) disable iff (!rstN)
    singlePanel |-> !hfbEn); // R9
  AST_GATE_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && regWe && regAddr == ADDR_W'(MISC_ADDR) && !regWdata[DATA_W-1])
      |=> hostAccessOk); // R7
  AST_BLOCKED_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && !regWe && !hostAccessOk && regAddr != ADDR_W'(STAT_ADDR)
      && regAddr != ADDR_W'(MISC_ADDR)) |=> (regRdata == '0)); // R8
  AST_BLOCKED_WRITE_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && regWe && !hostAccessOk && regAddr == ADDR_W'(PWR_ADDR))
      |=> ($stable(pwrDisQ) && $stable(suspReq))); // R8

endmodule

bind psave_ctrl psave_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_ADDR(STAT_ADDR),
  .MISC_ADDR(MISC_ADDR), .PWR_ADDR(PWR_ADDR)
) i_chk (
  .clk(clk), .rstN(rstN), .seqPwrOn(seqPwrOn), .singlePanel(singlePanel),
  .regReq(regReq), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
  .regAck(regAck), .regRdata(regRdata), .panelPwr(panelPwr), .suspReq(suspReq),
  .refMode(refMode), .hfbEn(hfbEn), .hostAccessOk(hostAccessOk),
  .pwrDisQ(pwrDisQ), .offPolQ(offPolQ)
);

// File: tb/test_psave_ctrl.sv
`timescale 1ns/1ps
module test_psave_ctrl;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              strapPwrPol = 1'b0;
  logic              seqPwrOn = 1'b0;
  logic              singlePanel = 1'b0;
  logic              regReq = 1'b0;
  logic              regWe = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [DATA_W-1:0] regWdata = '0;
  logic              regAck;
  logic [DATA_W-1:0] regRdata;
  logic              panelPwr;
  logic              suspReq;
  logic [1:0]        refMode;
  logic              hfbEn;
  logic              hostAccessOk;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;

  // model state
  bit       mHdis, mHfb, mPdis, mSusp, mPol;
  bit [1:0] mRef;

  always #5 clk = ~clk;

  psave_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_psave_ctrl (
    .clk(clk), .rstN(rstN), .strapPwrPol(strapPwrPol), .seqPwrOn(seqPwrOn),
    .singlePanel(singlePanel), .regReq(regReq), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regAck(regAck), .regRdata(regRdata), .panelPwr(panelPwr),
    .suspReq(suspReq), .refMode(refMode), .hfbEn(hfbEn), .hostAccessOk(hostAccessOk)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit [1:0] expRef(input bit [1:0] f);
    return f[1] ? 2'b10 : f;
  endfunction

  function automatic bit [7:0] expRead(input bit [3:0] a, input bit sp);
    bit [7:0] w = '0;
    case (a)
      4'd0: begin w[0] = mPol; w[1] = mSusp; w[2] = sp; end
      4'd1: begin w[7] = mHdis; w[0] = mHfb; end
      4'd2: begin w[0] = mSusp; w[2:1] = mRef; w[3] = mPdis; end
      default: w = '0;
    endcase
    return w;
  endfunction

  task automatic doReset(input bit strap);
    @(negedge clk);
    rstN = 1'b0; strapPwrPol = strap; regReq = 1'b0; seqPwrOn = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 ack in reset", regAck, 0);
    chk("R1 panel off in reset", panelPwr, strap);
    rstN = 1'b1;
    mHdis = 1; mHfb = 0; mPdis = 0; mSusp = 0; mRef = 0; mPol = strap;
  endtask

  task automatic step(input bit req, input bit we, input bit [3:0] addr,
                      input bit [7:0] wd, input bit seq, input bit sp, input string tag);
    bit allowed, expPwr;
    bit [7:0] expRd;
    @(negedge clk);
    regReq = req; regWe = we; regAddr = addr; regWdata = wd;
    seqPwrOn = seq; singlePanel = sp;
    expPwr  = mPdis ? mPol : (seq ? ~mPol : mPol);
    allowed = !mHdis || addr == 4'd0 || addr == 4'd1;
    expRd   = (req && !we && allowed) ? expRead(addr, sp) : 8'h00;
    if (req && we && allowed) begin
      if (addr == 4'd2) begin
        if (!mSusp) mRef = wd[2:1];
        mSusp = wd[0]; mPdis = wd[3];
      end else if (addr == 4'd1) begin
        mHdis = wd[7]; mHfb = wd[0];
      end
    end
    @(posedge clk);
    #2;
    chk({"R10 ack ", tag}, regAck, req);
    chk({"R8 R10 R11 rdata ", tag}, regRdata, expRd);
    chk({"R3 panelPwr ", tag}, panelPwr, expPwr);
    chk({"R5 suspReq ", tag}, suspReq, mSusp);
    chk({"R4 R6 refMode ", tag}, refMode, expRef(mRef));
    chk({"R7 hostAccessOk ", tag}, hostAccessOk, !mHdis);
    chk({"R9 hfbEn ", tag}, hfbEn, !mHfb && !sp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nErrors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1 / R2: strap 1 then strap 0
    doReset(1'b1);
    step(0, 0, 0, 0, 0, 0, "R1 idle after reset");
    chk("R1 hostAccessOk reset", hostAccessOk, 0);
    step(1, 0, 0, 0, 0, 0, "R11 status strap1");
    strapPwrPol = 1'b0;
    step(0, 0, 0, 0, 1, 0, "R2 strap change ignored on");
    step(0, 0, 0, 0, 0, 1, "R2 strap change ignored off");
    doReset(1'b0);
    step(0, 0, 0, 0, 0, 0, "R1 idle strap0");
    step(1, 0, 4'd1, 0, 0, 0, "R7 misc reads gate set");
    // R8: blocked accesses
    step(1, 1, 4'd2, 8'hFF, 1, 0, "R8 blocked write");
    step(1, 0, 4'd2, 0, 1, 0, "R8 blocked read");
    step(1, 0, 4'd5, 0, 1, 1, "R8 blocked unmapped read");
    // open the gate
    step(1, 1, 4'd1, 8'h7E, 1, 0, "R7 clear gate");
    step(1, 0, 4'd1, 0, 1, 0, "R11 misc unused bits zero");
    // R4: each refresh code
    step(1, 1, 4'd2, 8'h02, 1, 0, "R4 self");
    step(1, 1, 4'd2, 8'h04, 1, 0, "R4 none 10");
    step(1, 1, 4'd2, 8'h06, 1, 0, "R4 none 11");
    step(1, 1, 4'd2, 8'h00, 1, 0, "R4 cbr");
    // R3: override then release
    step(1, 1, 4'd2, 8'h08, 1, 0, "R3 force off");
    step(0, 0, 0, 0, 1, 0, "R3 forced");
    step(1, 1, 4'd2, 8'h00, 1, 0, "R3 release");
    step(0, 0, 0, 0, 1, 0, "R3 follows seq");
    // R5 / R6: suspend lock
    step(1, 1, 4'd2, 8'h03, 1, 0, "R5 suspend with self");
    step(1, 1, 4'd2, 8'h05, 1, 0, "R6 ref write ignored");
    step(1, 0, 4'd2, 0, 1, 0, "R6 readback");
    step(1, 1, 4'd2, 8'h04, 1, 0, "R6 release keeps ref");
    step(1, 1, 4'd2, 8'h04, 1, 0, "R6 ref now writable");
    // R9
    step(1, 1, 4'd1, 8'h01, 1, 0, "R9 hfb disabled");
    step(1, 1, 4'd1, 8'h00, 1, 1, "R9 single panel");
    step(0, 0, 0, 0, 0, 0, "R9 dual enabled");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      bit [3:0] a;
      bit [7:0] d;
      a = 4'($urandom % 5);
      d = 8'($urandom);
      if (a == 4'd1 && ($urandom % 4) != 0) d[7] = 1'b0;
      step(($urandom % 10) < 7, $urandom % 2, a, d, $urandom % 2, ($urandom % 4) == 0, "random");
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule